// File: doc/BRIEF.md
# Fractional clock output divider

This block turns a fast source clock into a slower square-wave clock whose period is a non-integer multiple of the source period. The overall ratio is 2·(N + F/2^24)·P. N is a 4-bit whole part, F is a 24-bit fraction and P is a post-divide factor of 1, 2 or 4. An internal clock toggles at the end of every half-period. Each half-period lasts N source cycles, or N+1 cycles when a 24-bit phase accumulator carries. A toggle chain then divides that internal clock by P.

The whole part, the fraction and the post-divide select can be changed while the block runs. The whole part and the fraction take effect at the next half-period boundary. The post-divide select takes effect only at the point where every divide stage is low, so no short pulse reaches the output. Dropping the enable clears the accumulator and all counters and drives the output low. The next enable starts a fresh, predictable sequence. The reset is asserted asynchronously and released in step with the source clock.

Top module: `frac_clk_div`

## Requirements
- R1: With the fraction at zero, every output level lasts exactly N·P source cycles, so the duty cycle is 50%.
- R2: Half-periods are numbered k = 0, 1, 2 from enable. Half-period 0 lasts N cycles, with the accumulator cleared. At each later boundary the fraction is added to the 24-bit accumulator, and the carry out of bit 23 adds one cycle to that half-period.
- R3: The post-divide select encodes 2'b00 as P=1, 2'b01 as P=2, 2'b10 as P=4, and 2'b11 also as P=4. Output level j (j ≥ 0, counted after the first output edge) spans half-periods 1+jP through P+jP.
- R4: A whole part below 5 (the values 0 to 4) behaves exactly as the value 5.
- R5: A new whole part written during a half-period has no effect on that half-period. It applies from the next half-period onward.
- R6: A change of post-divide select is applied only where all divide stages are low. No output level is ever shorter than 5 source cycles, and the output is low in the cycle where a new select takes effect.
- R7: In the cycle after the enable drops, the output is low, and it stays low while the enable is low. On re-enable, the first rising output edge comes exactly N cycles later, and the next half-period starts from a cleared accumulator.
- R8: The output is low while reset is asserted, and it stays low after reset until the block is enabled.
- R9: No output level lasts longer than 64 source cycles, which is 16·4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | High-rate source clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| int_val | input | 4 | Whole part N of the half-period length |
| frac_val | input | 24 | Fraction F, in units of 2^-24 |
| post_sel | input | 2 | Post-divide select (see R3) |
| enable | input | 1 | Runs the divider when high; clears it when low |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench builds the block with its default parameters: a 4-bit whole part, a 24-bit fraction, two post-divide stages and a minimum whole part of 5. These values reach every post-divide factor, including the duplicate 2'b11 code. They also reach the clamp region from 0 to 4 and fractions from a few LSBs up to all ones, which gives the longest level of 64 cycles. An independent accumulator model predicts every output level, so both the dithering order and a select switched while running are checked one cycle at a time.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    POST_BY1  = 2'b00,
    POST_BY2  = 2'b01,
    POST_BY4  = 2'b10,
    POST_BY4B = 2'b11
  } post_sel_e;

  // number of toggle stages that follow the internal half-period clock
  function automatic int unsigned post_stages(input logic [1:0] sel);
    case (post_sel_e'(sel))
      POST_BY1: return 0;
      POST_BY2: return 1;
      default:  return 2;
    endcase
  endfunction

endpackage

// File: rtl/fcd_rst_sync.sv
module fcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/fcd_phase.sv
module fcd_phase #(
  parameter int INT_W   = 4,
  parameter int FRAC_W  = 24,
  parameter int INT_MIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [INT_W-1:0]  int_val,
  input  logic [FRAC_W-1:0] frac_val,
  output logic              tog
);

  localparam int LEN_W = INT_W + 1;
  localparam logic [INT_W-1:0] MIN_V   = INT_W'(INT_MIN);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [LEN_W-1:0]  int_eff;
  logic [FRAC_W:0]   acc_sum;
  logic              last_cyc;

  always_comb begin
    int_eff  = (int_val < MIN_V) ? {1'b0, MIN_V} : {1'b0, int_val};
    acc_sum  = {1'b0, acc_q} + {1'b0, frac_val};
    last_cyc = (cnt_q == (len_q - LEN_ONE));
    tog      = run & last_cyc;
  end

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    acc_d = acc_q;
    if (!run) begin
      cnt_d = '0;
      acc_d = '0;
      len_d = int_eff;
    end else if (last_cyc) begin
      cnt_d = '0;
      acc_d = acc_sum[FRAC_W-1:0];
      len_d = int_eff + {{(LEN_W-1){1'b0}}, acc_sum[FRAC_W]};
    end else begin
      cnt_d = cnt_q + LEN_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= LEN_W'(INT_MIN);
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      len_q <= len_d;
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/fcd_post.sv
module fcd_post
  import fcd_pkg::*;
#(
  parameter int POST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tog,
  input  logic [1:0] post_sel,
  output logic       clk_out,
  output logic [1:0] post_q_o
);

  localparam int N = POST_STAGES;

  logic [N:0]   stg_q, stg_d;
  logic [N-1:0] rise;
  logic [1:0]   post_q, post_d;
  logic         out_q, out_d;
  logic         cap;

  // a rising edge of stage i-1 toggles stage i
  assign rise[0] = tog & ~stg_q[0];
  generate
    for (genvar gi = 1; gi < N; gi++) begin : g_rise
      assign rise[gi] = rise[gi-1] & ~stg_q[gi];
    end
  endgenerate

  always_comb begin
    int unsigned need;
    stg_d[0] = stg_q[0] ^ tog;
    for (int i = 1; i <= N; i++) stg_d[i] = stg_q[i] ^ rise[i-1];
    if (!run) stg_d = '0;

    // every stage falls to zero at this boundary
    cap    = tog & stg_q[0] & ~(|stg_q[N:1]);
    post_d = (!run || cap) ? post_sel : post_q;

    need = post_stages(post_d);
    if (need > N) need = N;
    out_d = 1'b0;
    for (int i = 0; i <= N; i++) begin
      if (i == int'(need)) out_d = stg_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      post_q <= 2'b00;
      out_q  <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      post_q <= post_d;
      out_q  <= out_d;
    end
  end

  assign clk_out  = out_q;
  assign post_q_o = post_q;

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
  parameter int INT_W       = 4,
  parameter int FRAC_W      = 24,
  parameter int INT_MIN     = 5,
  parameter int POST_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_val,
  input  logic [FRAC_W-1:0] frac_val,
  input  logic [1:0]        post_sel,
  input  logic              enable,
  output logic              clk_out
);

  logic       rst_s_n;
  logic       tog;
  logic [1:0] post_q;

  fcd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk_src),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s_n)
  );

  fcd_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W), .INT_MIN(INT_MIN)) u_phase (
    .clk      (clk_src),
    .rst_n    (rst_s_n),
    .run      (enable),
    .int_val  (int_val),
    .frac_val (frac_val),
    .tog      (tog)
  );

  fcd_post #(.POST_STAGES(POST_STAGES)) u_post (
    .clk      (clk_src),
    .rst_n    (rst_s_n),
    .run      (enable),
    .tog      (tog),
    .post_sel (post_sel),
    .clk_out  (clk_out),
    .post_q_o (post_q)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int INT_W       = 4,
  parameter int INT_MIN     = 5,
  parameter int POST_STAGES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       clk_out,
  input logic [1:0] post_q
);

  localparam int MAX_LEVEL = (2 ** INT_W) * (2 ** POST_STAGES);
  localparam int HW = $clog2(MAX_LEVEL + 2) + 1;
  localparam logic [HW-1:0] HOLD_ONE = HW'(1);

  logic [HW-1:0] hold_q;
  logic          seen_q;
  logic          prev_q;
  logic          edge_seen;

  assign edge_seen = (clk_out != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      seen_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= clk_out;
      if (!enable) begin
        hold_q <= '0;
        seen_q <= 1'b0;
      end else if (edge_seen) begin
        hold_q <= HOLD_ONE;
        seen_q <= 1'b1;
      end else if (hold_q != '1) begin
        hold_q <= hold_q + HOLD_ONE;
      end
    end
  end

  // R7: output low once the enable is low
  p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !clk_out);

  // R6: no level shorter than the minimum half-period
  p_min_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && seen_q && edge_seen) |-> (hold_q >= HW'(INT_MIN)));

  // R9: no level longer than the largest half-period times the largest factor
  p_max_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (hold_q <= HW'(MAX_LEVEL)));

  // R6: a new post-divide select appears only with the output low
  p_post_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(post_q) |-> !clk_out);

endmodule

bind frac_clk_div fcd_checker #(
  .INT_W       (INT_W),
  .INT_MIN     (INT_MIN),
  .POST_STAGES (POST_STAGES)
) u_fcd_checker (
  .clk     (clk_src),
  .rst_n   (rst_n),
  .enable  (enable),
  .clk_out (clk_out),
  .post_q  (post_q)
);

// File: tb/tb_frac_clk_div.sv
module tb_frac_clk_div;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk_src;
  logic        rst_n;
  logic [3:0]  int_val;
  logic [23:0] frac_val;
  logic [1:0]  post_sel;
  logic        enable;
  logic        clk_out;

  int n_checks;
  int n_err;

  int    exp_q[$];
  string cur_tag;
  bit    floor_mode;
  int    floor_val;
  int    tog_cnt;
  int    hold;
  int    max_hold;
  bit    seen;
  logic  prev;

  frac_clk_div dut (
    .clk_src  (clk_src),
    .rst_n    (rst_n),
    .int_val  (int_val),
    .frac_val (frac_val),
    .post_sel (post_sel),
    .enable   (enable),
    .clk_out  (clk_out)
  );

  initial clk_src = 1'b0;
  always #(CLK_PERIOD/2) clk_src = ~clk_src;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  // monitor: measures every output level and scores it
  initial begin
    seen = 1'b0; hold = 0; tog_cnt = 0; prev = 1'b0; max_hold = 0;
    forever begin
      @(negedge clk_src);
      if (!enable) begin
        seen = 1'b0; hold = 0; tog_cnt = 0;
      end else begin
        hold++;
        if (clk_out !== prev) begin
          tog_cnt++;
          if (seen) begin
            if (hold > max_hold) max_hold = hold;
            if (floor_mode) begin
              check(hold >= floor_val, cur_tag, "level length floor", hold, floor_val);
            end else if (exp_q.size() > 0) begin
              int e;
              e = exp_q.pop_front();
              check(hold == e, cur_tag, "level length", hold, e);
            end
          end
          seen = 1'b1;
          hold = 0;
        end
      end
      prev = clk_out;
    end
  end

  function automatic int clamp_int(input int i);
    return (i < 5) ? 5 : i;
  endfunction

  function automatic int factor(input int s);
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  // driver: computes the expected level lengths and pushes them
  task automatic push_levels(input int i, input int f, input int s, input int n);
    int ie, p, acc, sum, lens[$];
    ie = clamp_int(i);
    p  = factor(s);
    acc = 0;
    lens.push_back(ie);
    for (int k = 1; k <= n * p + 1; k++) begin
      sum = acc + f;
      acc = sum & 24'hFFFFFF;
      lens.push_back(ie + (sum >> 24));
    end
    for (int j = 0; j < n; j++) begin
      int tot;
      tot = 0;
      for (int m = 1; m <= p; m++) tot += lens[m + j * p];
      exp_q.push_back(tot);
    end
  endtask

  task automatic tick();
    @(posedge clk_src);
    #1;
  endtask

  task automatic run_cfg(input int i, input int f, input int s, input int n,
                         input string tag);
    tick();
    enable = 1'b0; int_val = 4'(i); frac_val = 24'(f); post_sel = 2'(s);
    cur_tag = tag;
    repeat (2) tick();
    push_levels(i, f, s, n);
    enable = 1'b1;
    while (exp_q.size() != 0) tick();
    enable = 1'b0;
    tick();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_src);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    n_checks = 0; n_err = 0;
    floor_mode = 1'b0; floor_val = 0; cur_tag = "R8";
    rst_n = 1'b0; enable = 1'b0;
    int_val = 4'd5; frac_val = '0; post_sel = 2'b00;

    // R8: reset state
    repeat (4) tick();
    check(clk_out == 1'b0, "R8", "output during reset", int'(clk_out), 0);
    rst_n = 1'b1;
    repeat (6) tick();
    check(clk_out == 1'b0, "R8", "output after reset, disabled", int'(clk_out), 0);

    // R1 / R3: integer ratios under each post-divide code
    run_cfg(5, 0, 0, 8, "R1");
    run_cfg(7, 0, 1, 6, "R1/R3");
    run_cfg(6, 0, 2, 5, "R3");
    run_cfg(5, 0, 3, 5, "R3 code 11");

    // R2: fractional dithering
    run_cfg(5, 24'h800000, 0, 12, "R2 half");
    run_cfg(9, 24'h555555, 1, 10, "R2 third");
    run_cfg(11, 24'h000123, 0, 10, "R2 small");
    max_hold = 0;
    run_cfg(15, 24'hFFFFFF, 2, 6, "R2/R9");
    check(max_hold <= 64, "R9", "longest level", max_hold, 64);

    // R4: clamping of small whole parts
    run_cfg(2, 0, 0, 6, "R4");
    run_cfg(0, 24'h400000, 1, 6, "R4 frac");

    // R5: whole part rewritten while running
    tick();
    int_val = 4'd8; frac_val = '0; post_sel = 2'b00; cur_tag = "R5";
    repeat (2) tick();
    for (int j = 0; j < 4; j++) exp_q.push_back(8);
    for (int j = 0; j < 8; j++) exp_q.push_back(11);
    enable = 1'b1;
    while (tog_cnt < 4) tick();
    int_val = 4'd11;
    while (exp_q.size() != 0) tick();
    enable = 1'b0;
    tick();

    // R6: post-divide select switched while running
    int_val = 4'd5; post_sel = 2'b00; cur_tag = "R6";
    floor_mode = 1'b1; floor_val = 5;
    repeat (2) tick();
    enable = 1'b1;
    while (tog_cnt < 5) tick();
    post_sel = 2'b10;
    while (tog_cnt < 12) tick();
    floor_mode = 1'b0;
    for (int j = 0; j < 3; j++) exp_q.push_back(20);
    while (exp_q.size() != 0) tick();
    enable = 1'b0;
    tick();

    // R7: disable and restart
    int_val = 4'd6; frac_val = 24'hFFFFFF; post_sel = 2'b00; cur_tag = "R7";
    repeat (2) tick();
    enable = 1'b1;
    while (tog_cnt < 3) tick();
    while (clk_out != 1'b1) tick();
    enable = 1'b0;
    tick();
    check(clk_out == 1'b0, "R7", "output one cycle after disable", int'(clk_out), 0);
    begin
      int highs;
      highs = 0;
      repeat (20) begin
        tick();
        if (clk_out) highs++;
      end
      check(highs == 0, "R7", "high cycles while disabled", highs, 0);
    end
    enable = 1'b1;
    repeat (5) tick();
    check(clk_out == 1'b0, "R7", "output before first edge", int'(clk_out), 0);
    tick();
    check(clk_out == 1'b1, "R7", "first rising edge after N cycles", int'(clk_out), 1);
    repeat (5) tick();
    check(clk_out == 1'b1, "R7", "second half not extended early", int'(clk_out), 1);
    tick();
    check(clk_out == 1'b0, "R7", "second half from cleared accumulator", int'(clk_out), 0);
    enable = 1'b0;
    repeat (3) tick();

    summary();
    $finish;
  end

endmodule